// File: doc/BRIEF.md
# Paged ROM and RAM Memory Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and two synchronous memories: a cartridge ROM of up to several hundred kilobytes and an 8 KB work RAM. The lower three quarters of the CPU space (0x0000 to 0xBFFF) form three 16 KB ROM windows, selected by address bits 15:14. Each window shows whichever 16 KB ROM bank its paging register names. The upper quarter (0xC000 to 0xFFFF) holds the 8 KB RAM twice, indexed by address bits 12:0.

The paging registers have no address space of their own. A CPU write to 0xFFFC, 0xFFFD or 0xFFFE stores the data byte in RAM like any other RAM write, and the mapper also captures it as the bank number for window 0, 1 or 2 respectively. The number of banks is the ROM size, set by the `ROM_BYTES` parameter, divided by 16 KB and rounded up to a power of two. A bank number is reduced modulo that count by keeping only its low bits. Any ROM byte at or beyond `ROM_BYTES`, including the missing tail of a ROM that is not a power-of-two size, reads back as 0xFF and causes no ROM access.

The mapper registers the memory strobes and addresses one cycle after a CPU request. It returns read data, with a valid flag, two cycles after the request.

Top module: `slot_pager`

## Requirements
- R1: A read with address bits 15:14 equal to 0, 1 or 2 pulses `rom_rd` in the next cycle, with `rom_addr` = (bank of that window) × 16384 + address bits 13:0.
- R2: A read at 0xC000–0xFFFF pulses `ram_rd` in the next cycle with `ram_addr` = address bits 12:0, so 0xE000–0xFFFF alias 0xC000–0xDFFF.
- R3: A write at 0xC000–0xFFFF pulses `ram_we` in the next cycle, with `ram_addr` = address bits 12:0 and `ram_wdata` = the written byte.
- R4: A write below 0xC000 raises no `ram_we` and no `rom_rd`, and leaves every window's bank unchanged.
- R5: A write to 0xFFFC, 0xFFFD or 0xFFFE (address bits 1:0 = 0, 1, 2) sets the bank of window 0, 1 or 2, and still writes RAM. The new bank applies from the next request on. A write to 0xFFFF changes no bank.
- R6: The stored bank number is the written byte modulo the bank count, where the bank count is ceil(`ROM_BYTES`/16384) rounded up to a power of two.
- R7: A read whose ROM address is at or beyond `ROM_BYTES` raises no `rom_rd` and returns 0xFF with `cpu_rvalid` high.
- R8: After reset, windows 0, 1 and 2 map banks 0, 1 and 2 (each modulo the bank count), and no strobe or `cpu_rvalid` is high.
- R9: Read data appears on `cpu_rdata` with `cpu_rvalid` high for exactly one cycle, two cycles after a one-cycle read request. Writes raise no `cpu_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | One-cycle read request |
| cpu_wr | input | 1 | One-cycle write request |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| cpu_rvalid | output | 1 | Marks the cycle `cpu_rdata` is valid |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | PHYS_W | ROM byte address (17 bits by default) |
| rom_rdata | input | 8 | ROM data, one cycle after `rom_rd` |
| ram_rd | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 13 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM data, one cycle after `ram_rd` |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never both high in one cycle and that both are low while reset is held. They also assume that each memory returns data exactly one cycle after its strobe. The stimulus issues one request, leaves the bus idle until the data has returned, and drives requests only after reset is released. Both memories are modelled in the bench with a one-cycle synchronous read. A second instance with a ROM size that is not a power of two covers the masking and the 0xFF fill.

// File: rtl/slot_pager_pkg.sv
package slot_pager_pkg;

  localparam int WINDOW_BITS = 14;
  localparam int NUM_WINDOWS = 3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2,
    SRC_VOID = 2'd3
  } src_t;

  function automatic int unsigned bank_need(input int unsigned rom_bytes);
    return (rom_bytes + (1 << WINDOW_BITS) - 1) >> WINDOW_BITS;
  endfunction

endpackage

// File: rtl/slot_pager_pages.sv
module slot_pager_pages
  import slot_pager_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 3,
  parameter int BANK_MASK = 7
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [NUM_WINDOWS-1:0][BANK_W-1:0]  bank_q
);

  localparam logic [ADDR_W-3:0] PAGE_TOP = '1;

  logic page_zone;
  assign page_zone = (addr[ADDR_W-1:2] == PAGE_TOP);

  for (genvar w = 0; w < NUM_WINDOWS; w++) begin : g_win
    localparam logic [BANK_W-1:0] RST_BANK = BANK_W'(w & BANK_MASK);
    logic hit;
    assign hit = wr_en && page_zone && (addr[1:0] == 2'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[w] <= RST_BANK;
      end else if (hit) begin
        bank_q[w] <= wdata[BANK_W-1:0] & BANK_W'(BANK_MASK);
      end
    end

    // R8: first cycle out of reset shows the default bank
    assert_reset_map_R8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> bank_q[w] == RST_BANK);
  end

  // R4, R5: banks move only on a write into the paging bytes
  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && page_zone) |=> $stable(bank_q));

endmodule

// File: rtl/slot_pager_decode.sv
module slot_pager_decode
  import slot_pager_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_W    = 3,
  parameter int PHYS_W    = 17,
  parameter int RAM_AW    = 13,
  parameter int ROM_BYTES = 131072
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic                                rd,
  input  logic                                wr,
  input  logic [NUM_WINDOWS-1:0][BANK_W-1:0]  bank_q,
  output src_t                                rd_src,
  output logic [PHYS_W-1:0]                   phys,
  output logic                                ram_we,
  output logic [RAM_AW-1:0]                   ram_a
);

  logic [1:0]        window;
  logic              in_ram;
  logic [BANK_W-1:0] bank_sel;
  logic              present;
  logic              rd_eff;

  assign window = addr[ADDR_W-1:ADDR_W-2];
  assign in_ram = (window == 2'd3);
  assign rd_eff = rd && !wr;
  assign ram_a  = addr[RAM_AW-1:0];

  always_comb begin
    bank_sel = '0;
    for (int w = 0; w < NUM_WINDOWS; w++) begin
      if (window == 2'(w)) bank_sel = bank_q[w];
    end
  end

  assign phys    = {bank_sel, addr[WINDOW_BITS-1:0]};
  assign present = (32'(phys) < 32'(ROM_BYTES));
  assign ram_we  = wr && in_ram;

  always_comb begin
    if (!rd_eff)      rd_src = SRC_NONE;
    else if (in_ram)  rd_src = SRC_RAM;
    else if (present) rd_src = SRC_ROM;
    else              rd_src = SRC_VOID;
  end

endmodule

// File: rtl/slot_pager_return.sv
module slot_pager_return
  import slot_pager_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  src_t              issue_src,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid
);

  src_t stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= SRC_NONE;
      stage2 <= SRC_NONE;
    end else begin
      stage1 <= issue_src;
      stage2 <= stage1;
    end
  end

  assign cpu_rvalid = (stage2 != SRC_NONE);

  always_comb begin
    unique case (stage2)
      SRC_ROM: cpu_rdata = rom_rdata;
      SRC_RAM: cpu_rdata = ram_rdata;
      default: cpu_rdata = '1;
    endcase
  end

endmodule

// File: rtl/slot_pager.sv
module slot_pager
  import slot_pager_pkg::*;
#(
  parameter int ROM_BYTES = 131072,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int RAM_AW    = 13,
  localparam int NEED     = (bank_need(ROM_BYTES) < 1) ? 1 : int'(bank_need(ROM_BYTES)),
  localparam int BANK_CNT = 1 << $clog2(NEED),
  localparam int BANK_W   = (BANK_CNT < 2) ? 1 : $clog2(BANK_CNT),
  localparam int PHYS_W   = BANK_W + WINDOW_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic              rom_rd,
  output logic [PHYS_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              ram_rd,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);

  localparam int BANK_MASK = BANK_CNT - 1;

  logic [NUM_WINDOWS-1:0][BANK_W-1:0] bank_q;
  src_t              dec_src;
  logic [PHYS_W-1:0] dec_phys;
  logic              dec_we;
  logic [RAM_AW-1:0] dec_ram_a;

  slot_pager_pages #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .BANK_MASK(BANK_MASK)
  ) u_pages (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .addr(cpu_addr),
    .wdata(cpu_wdata), .bank_q(bank_q)
  );

  slot_pager_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PHYS_W(PHYS_W),
    .RAM_AW(RAM_AW), .ROM_BYTES(ROM_BYTES)
  ) u_dec (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .bank_q(bank_q),
    .rd_src(dec_src), .phys(dec_phys), .ram_we(dec_we), .ram_a(dec_ram_a)
  );

  slot_pager_return #(.DATA_W(DATA_W)) u_ret (
    .clk(clk), .rst(rst), .issue_src(dec_src),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_rd    <= 1'b0;
      ram_rd    <= 1'b0;
      ram_we    <= 1'b0;
      rom_addr  <= '0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      rom_rd    <= (dec_src == SRC_ROM);
      ram_rd    <= (dec_src == SRC_RAM);
      ram_we    <= dec_we;
      rom_addr  <= dec_phys;
      ram_addr  <= dec_ram_a;
      ram_wdata <= cpu_wdata;
    end
  end

  // R2: never both memories in one cycle
  assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
    !(rom_rd && (ram_rd || ram_we)));

  // R7: the ROM is never addressed past its end
  assert_rom_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    rom_rd |-> 32'(rom_addr) < 32'(ROM_BYTES));

  // R3: a write into the top quarter lands in RAM with the mirrored address
  assert_ram_write_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'd3) |=>
      (ram_we && ram_addr == $past(cpu_addr[RAM_AW-1:0])));

  // R4: a write never touches the ROM
  assert_wr_no_rom_R4: assert property (@(posedge clk) disable iff (rst)
    cpu_wr |=> !rom_rd);

  // R9: a ROM strobe is followed by returned data
  assert_rom_return_R9: assert property (@(posedge clk) disable iff (rst)
    rom_rd |=> cpu_rvalid);

  // R7: data without a preceding memory strobe is the fill byte
  assert_void_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_rvalid && !$past(rom_rd) && !$past(ram_rd)) |-> cpu_rdata == '1);

endmodule

// File: tb/sim_slot_pager.sv
`timescale 1ns/100ps
module sim_slot_pager;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;

  logic [7:0]  rdata0, rdata1;
  logic        rvalid0, rvalid1;
  logic        rom_rd0, rom_rd1, ram_rd0, ram_rd1, ram_we0, ram_we1;
  logic [16:0] rom_addr0;
  logic [15:0] rom_addr1;
  logic [12:0] ram_addr0, ram_addr1;
  logic [7:0]  ram_wdata0, ram_wdata1;
  logic [7:0]  rom_q0 = '0, rom_q1 = '0, ram_q0 = '0;
  logic [7:0]  ram_mem [0:8191];

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [31:0] a);
    return a[7:0] ^ a[21:14] ^ 8'h3C ^ {a[13:10], 4'h0};
  endfunction

  slot_pager u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(rdata0), .cpu_rvalid(rvalid0),
    .rom_rd(rom_rd0), .rom_addr(rom_addr0), .rom_rdata(rom_q0),
    .ram_rd(ram_rd0), .ram_we(ram_we0), .ram_addr(ram_addr0),
    .ram_wdata(ram_wdata0), .ram_rdata(ram_q0)
  );

  // 40 KB ROM: four banks, the last 24 KB absent
  slot_pager #(.ROM_BYTES(40960)) u1 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(rdata1), .cpu_rvalid(rvalid1),
    .rom_rd(rom_rd1), .rom_addr(rom_addr1), .rom_rdata(rom_q1),
    .ram_rd(ram_rd1), .ram_we(ram_we1), .ram_addr(ram_addr1),
    .ram_wdata(ram_wdata1), .ram_rdata(8'h00)
  );

  initial for (int i = 0; i < 8192; i++) ram_mem[i] = 8'h00;

  always @(posedge clk) begin
    if (rom_rd0) rom_q0 <= rom_byte(32'(rom_addr0));
    if (rom_rd1) rom_q1 <= rom_byte(32'(rom_addr1));
    if (ram_we0) ram_mem[ram_addr0] <= ram_wdata0;
    if (ram_rd0) ram_q0 <= ram_mem[ram_addr0];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // drive one request; return after the address stage is visible
  task automatic issue(input bit rd, input bit wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
  endtask

  // op: 0 ROM read (val = expected ROM address), 1 RAM read (val = data),
  //     2 write (val = data)
  localparam int NV = 21;
  localparam logic [41:0] VEC [0:NV-1] = '{
    {2'd0, 16'h0123, 24'h000123},  // R1 R8 window 0 -> bank 0
    {2'd0, 16'h4567, 24'h004567},  // R1 R8 window 1 -> bank 1
    {2'd0, 16'h89AB, 24'h0089AB},  // R1 R8 window 2 -> bank 2
    {2'd2, 16'hC010, 24'h00005A},  // R3
    {2'd1, 16'hC010, 24'h00005A},  // R2
    {2'd1, 16'hE010, 24'h00005A},  // R2 mirror
    {2'd2, 16'hFFFD, 24'h000005},  // R5 window 1 -> bank 5
    {2'd0, 16'h4001, 24'h014001},  // R5
    {2'd1, 16'hDFFD, 24'h000005},  // R5 RAM also written
    {2'd2, 16'hFFFE, 24'h00000B},  // R6 11 mod 8 = 3
    {2'd0, 16'hBFFF, 24'h00FFFF},  // R6
    {2'd2, 16'hFFFC, 24'h000007},  // R5 window 0 -> bank 7
    {2'd0, 16'h0000, 24'h01C000},  // R5
    {2'd2, 16'h4000, 24'h000077},  // R4 ignored write
    {2'd0, 16'h4002, 24'h014002},  // R4 bank 5 kept
    {2'd2, 16'hFFFF, 24'h000002},  // R5 not a paging byte
    {2'd0, 16'h0005, 24'h01C005},  // R5 window 0 still bank 7
    {2'd1, 16'hFFFF, 24'h000002},  // R2
    {2'd2, 16'hE123, 24'h000033},  // R3 through the mirror
    {2'd1, 16'hC123, 24'h000033},  // R2
    {2'd1, 16'hC200, 24'h000000}   // R2 untouched byte
  };

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 rom_rd", 32'(rom_rd0), 0);
    check("R8 ram_we", 32'(ram_we0), 0);
    check("R8 rvalid", 32'(rvalid0), 0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [15:0] a;
      logic [23:0] v;
      {op, a, v} = VEC[i];
      issue(op != 2'd2, op == 2'd2, a, v[7:0]);
      check("R9 rvalid early", 32'(rvalid0), 0);
      case (op)
        2'd0: begin
          check("R1 rom_rd", 32'(rom_rd0), 1);
          check("R1 rom_addr", 32'(rom_addr0), 32'(v));
          check("R1 ram_rd", 32'(ram_rd0), 0);
        end
        2'd1: begin
          check("R2 ram_rd", 32'(ram_rd0), 1);
          check("R2 ram_addr", 32'(ram_addr0), 32'(a[12:0]));
          check("R2 rom_rd", 32'(rom_rd0), 0);
        end
        default: begin
          check("R4 rom_rd on write", 32'(rom_rd0), 0);
          check("R3 ram_we", 32'(ram_we0), 32'(a >= 16'hC000));
          if (a >= 16'hC000) begin
            check("R3 ram_addr", 32'(ram_addr0), 32'(a[12:0]));
            check("R3 ram_wdata", 32'(ram_wdata0), 32'(v[7:0]));
          end
        end
      endcase
      @(negedge clk);
      if (op == 2'd2) begin
        check("R9 no rvalid on write", 32'(rvalid0), 0);
      end else begin
        check("R9 rvalid", 32'(rvalid0), 1);
        check("R9 rdata", 32'(rdata0),
              op == 2'd0 ? 32'(rom_byte(32'(v))) : 32'(v[7:0]));
      end
      @(negedge clk);
      check("R9 rvalid one cycle", 32'(rvalid0), 0);
    end

    // R8 reset in mid-run restores the default mapping
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    check("R8 rvalid after reset", 32'(rvalid0), 0);
    check("R8 ram_rd after reset", 32'(ram_rd0), 0);
    rst = 0;
    issue(1, 0, 16'h4000, 8'h00);
    check("R8 window 1 bank 1", 32'(rom_addr0), 32'h04000);
    check("R8 u1 window 1 bank 1", 32'(rom_addr1), 32'h04000);
    repeat (2) @(negedge clk);

    // R7 partial ROM on u1 (ROM_BYTES = 0xA000)
    issue(1, 0, 16'h9FFF, 8'h00);
    check("R7 last byte present", 32'(rom_rd1), 1);
    @(negedge clk);
    check("R7 last byte data", 32'(rdata1), 32'(rom_byte(32'h9FFF)));
    @(negedge clk);
    issue(1, 0, 16'hA000, 8'h00);
    check("R7 no rom_rd past end", 32'(rom_rd1), 0);
    @(negedge clk);
    check("R7 rvalid past end", 32'(rvalid1), 1);
    check("R7 fill byte", 32'(rdata1), 32'hFF);
    @(negedge clk);

    // R6 four banks on u1: 7 mod 4 = 3, absent; 6 mod 4 = 2
    issue(0, 1, 16'hFFFE, 8'h07);
    repeat (2) @(negedge clk);
    issue(1, 0, 16'h8000, 8'h00);
    check("R6 u0 bank 7", 32'(rom_addr0), 32'h1C000);
    check("R6 u1 bank 3 absent", 32'(rom_rd1), 0);
    @(negedge clk);
    check("R6 u1 fill", 32'(rdata1), 32'hFF);
    @(negedge clk);
    issue(0, 1, 16'hFFFC, 8'h06);
    repeat (2) @(negedge clk);
    issue(1, 0, 16'h0100, 8'h00);
    check("R6 u1 bank 2", 32'(rom_addr1), 32'h8100);
    check("R6 u1 present", 32'(rom_rd1), 1);
    check("R6 u0 bank 6", 32'(rom_addr0), 32'h18100);
    repeat (2) @(negedge clk);

    finish_run();
  end

endmodule